// File: doc/BRIEF.md
# Far-End Receiver Detection Sequencer

This block runs the digital half of a receiver-presence check on a serial transmit lane. A request bit asks for a check. The block first confirms that the lane's power-state input shows the low-power state. It then enables the line drivers that force both differential outputs to a mid-level common-mode voltage. After a fixed drive phase it releases them and waits a programmable number of cycles. At the end of that wait it samples a threshold comparator input. The comparator shows whether the lines crossed the threshold fast or slow, which tells whether a terminated far-end receiver is attached.

The outcome is placed on a 3-bit status bus for one cycle, marked by a single-cycle done strobe. A request made outside the low-power state produces a one-cycle error strobe, and no drive takes place. A request that stays high does not start repeated checks: the request must be seen low before another check can begin. The drivers, the comparator and the coupling network are outside the block. Everything runs on the transmit user clock.

Top module: `rxdet_seq`

## Requirements
- R1: `det_req` = 0 means normal operation and starts nothing. `det_req` = 1 sampled in idle while armed requests a detection.
- R2: A detection starts only if `pwr_state` equals the low-power code 2'b10 on the clock edge that samples the request.
- R3: A request sampled in idle while armed with `pwr_state` other than 2'b10 raises `err` for exactly one cycle, starting the cycle after that edge. `drv_en` stays low, and the block stays idle.
- R4: `drv_en` goes high in the cycle after the starting edge. It stays high for exactly DRIVE_CYCLES cycles (default 4).
- R5: After `drv_en` falls, the block waits the captured wait length with `drv_en` low. It samples `cmp_in` on the clock edge that ends the wait, which is DRIVE_CYCLES + wait cycles after the starting edge.
- R6: On the result cycle, `status` is 3'b011 if the sampled `cmp_in` was 1, and 3'b000 if it was 0.
- R7: `done` is high for exactly one cycle per completed sequence, in the cycle after the sampling edge.
- R8: `status` is 3'b000 in every cycle where `done` is low.
- R9: `wait_cfg` is captured on the starting edge, and later changes do not alter the running sequence. A captured value of 0 gives a wait of 1 cycle.
- R10: After reset, after a start and after an error, a new start needs `det_req` to have been sampled low on some edge since then.
- R11: A synchronous active-low reset `rst_n` returns the block to idle, not armed, with `drv_en`, `done`, `err` and `status` all 0 in the cycle after the reset edge.
- R12: Changes to `det_req` and `pwr_state` during a running sequence do not alter its timing or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit user clock |
| rst_n | input | 1 | Synchronous reset, active low |
| det_req | input | 1 | Detection request (1 = detect, 0 = normal) |
| pwr_state | input | 2 | Lane power state; 2'b10 is the low-power state |
| wait_cfg | input | 16 | Settling wait in cycles, captured at start |
| cmp_in | input | 1 | Threshold comparator output |
| drv_en | output | 1 | Drives lines to common mode while high |
| status | output | 3 | Detection result, valid with done |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | One-cycle strobe for a request outside the low-power state |

## Verification
The assertions assume that every input is synchronous to `clk` and is stable around the rising edge. They also assume that DRIVE_CYCLES is at least 1 and fits the wait counter. The bench changes every input only on the falling edge. During some sequences it toggles `cmp_in` every cycle, so only a sample taken on exactly the right edge matches the reference model. It also changes `wait_cfg`, `det_req` and `pwr_state` while a sequence runs, holds the request high across reset and after completion, and resets the block in the middle of a sequence.

// File: rtl/rxdet_pkg.sv
// Shared definitions for the receiver detection sequencer.
// Assumes: the status bus is 3 bits wide and uses the two codes below.
package rxdet_pkg;
    localparam int STAT_W = 3;
    localparam logic [STAT_W-1:0] STAT_FOUND = 3'b011;
    localparam logic [STAT_W-1:0] STAT_NONE  = 3'b000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_WAIT  = 2'd2
    } rxdet_state_e;
endpackage

// File: rtl/rxdet_timer.sv
// Loadable down-counter that times the drive phase and the settling wait.
// Assumes: load wins over dec; dec is only issued while the count is nonzero.
module rxdet_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: reset, load a new interval, or step down by one.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (dec)    cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag seen by the controller.
    assign zero = (cnt_q == '0);

    p_timer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q));
    p_timer_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/rxdet_report.sv
// Output registers for the result strobe, the status code and the error strobe.
// Assumes: finish and reject are each single-cycle and never coincide.
module rxdet_report
    import rxdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    input  logic              reject,
    input  logic              cmp_in,
    output logic              done,
    output logic [STAT_W-1:0] status,
    output logic              err
);
    // Register the result for one cycle, then fall back to the quiet code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            status <= STAT_NONE;
            err    <= 1'b0;
        end else begin
            done   <= finish;
            status <= (finish && cmp_in) ? STAT_FOUND : STAT_NONE;
            err    <= reject;
        end
    end

    p_done_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    p_status_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == STAT_FOUND || status == STAT_NONE));
endmodule

// File: rtl/rxdet_seq.sv
// Receiver detection sequencer: checks the power state, drives the lines to
// common mode, releases them, waits, samples the comparator and reports.
// Assumes: all inputs are synchronous to clk; DRIVE_CYCLES >= 1 and fits CNT_W.
module rxdet_seq
    import rxdet_pkg::*;
#(
    parameter int          WAIT_W       = 16,
    parameter int          DRIVE_CYCLES = 4,
    parameter logic [1:0]  P1_CODE      = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_req,
    input  logic [1:0]        pwr_state,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              cmp_in,
    output logic              drv_en,
    output logic [STAT_W-1:0] status,
    output logic              done,
    output logic              err
);
    localparam int CNT_W = WAIT_W;
    localparam logic [CNT_W-1:0] DRIVE_LOAD = CNT_W'(DRIVE_CYCLES - 1);

    rxdet_state_e      state_q, state_d;
    logic              armed_q;
    logic [WAIT_W-1:0] wait_q;
    logic              start, reject, finish;
    logic              tmr_load, tmr_dec, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;

    // Request qualification and next-state selection.
    always_comb begin
        start    = (state_q == ST_IDLE) && armed_q && det_req && (pwr_state == P1_CODE);
        reject   = (state_q == ST_IDLE) && armed_q && det_req && (pwr_state != P1_CODE);
        finish   = (state_q == ST_WAIT) && tmr_zero;
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = DRIVE_LOAD;
        tmr_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_DRIVE;
                    tmr_load = 1'b1;
                end
            end
            ST_DRIVE: begin
                if (tmr_zero) begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(wait_q - 1'b1);
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_zero) state_d = ST_IDLE;
                else          tmr_dec = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Re-arm flag: set by a low request, cleared when a request is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (!det_req)         armed_q <= 1'b1;
        else if (start || reject)  armed_q <= 1'b0;
    end

    // Capture the settling length at start, turning zero into one.
    always_ff @(posedge clk) begin
        if (!rst_n)     wait_q <= WAIT_W'(1);
        else if (start) wait_q <= (wait_cfg == '0) ? WAIT_W'(1) : wait_cfg;
    end

    assign drv_en = (state_q == ST_DRIVE);

    rxdet_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    rxdet_report i_report (
        .clk    (clk),
        .rst_n  (rst_n),
        .finish (finish),
        .reject (reject),
        .cmp_in (cmp_in),
        .done   (done),
        .status (status),
        .err    (err)
    );

    p_start_in_p1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> ($past(pwr_state) == P1_CODE && $past(det_req)));
    p_start_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> drv_en);
    p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !drv_en));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_status_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (status == STAT_NONE));
    p_release_before_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!drv_en && $past(!drv_en)));
    p_unarmed_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !armed_q) |=> !drv_en);
    p_wait_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q != '0);
endmodule

// File: tb/test_rxdet_seq.sv
module test_rxdet_seq;
    localparam int D = 4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        det_req = 1'b1;
    logic [1:0]  pwr_state = 2'b10;
    logic [15:0] wait_cfg = 16'd5;
    logic        cmp_in = 1'b0;
    logic        drv_en, done, err;
    logic [2:0]  status;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int m_st = 0, m_cnt = 0, m_wl = 1, m_done_cnt = 0, dut_done_cnt = 0;
    bit m_armed = 0, e_done = 0, e_err = 0, live = 0, finished = 0;
    logic [2:0] e_stat = 3'b000;

    always #4 clk = ~clk;

    rxdet_seq i_rxdet_seq (
        .clk(clk), .rst_n(rst_n), .det_req(det_req), .pwr_state(pwr_state),
        .wait_cfg(wait_cfg), .cmp_in(cmp_in), .drv_en(drv_en),
        .status(status), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Behavioural reference: advances one step per rising edge.
    always @(posedge clk) begin
        cyc++;
        live = 1;
        if (!rst_n) begin
            m_st = 0; m_armed = 0; e_done = 0; e_err = 0; e_stat = 3'b000;
        end else begin
            e_done = 0; e_err = 0; e_stat = 3'b000;
            if (m_st == 0) begin
                if (det_req && m_armed) begin
                    m_armed = 0;
                    if (pwr_state == 2'b10) begin
                        m_st = 1; m_cnt = D;
                        m_wl = (wait_cfg == 0) ? 1 : int'(wait_cfg);
                    end else e_err = 1;
                end
            end else if (m_st == 1) begin
                m_cnt--;
                if (m_cnt == 0) begin m_st = 2; m_cnt = m_wl; end
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin
                    e_done = 1; e_stat = cmp_in ? 3'b011 : 3'b000; m_st = 0; m_done_cnt++;
                end
            end
            if (!det_req) m_armed = 1;
        end
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (live && !finished) begin
            if (done === 1'b1) dut_done_cnt++;
            chk(drv_en === (m_st == 1), "R1,R2,R4,R5,R11,R12 drv_en", int'(drv_en), int'(m_st == 1));
            chk(err === e_err, "R2,R3,R11 err", int'(err), int'(e_err));
            chk(done === e_done, "R7,R10,R11 done", int'(done), int'(e_done));
            chk(status === e_stat, "R6,R8,R9,R11 status", int'(status), int'(e_stat));
        end
    end

    task automatic run(input int n, input bit toggle);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (toggle) cmp_in = ~cmp_in;
        end
    endtask

    task automatic summary;
        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        run(3, 0);
        rst_n = 1'b1;                       // R10: request held high out of reset
        run(5, 0);
        chk(drv_en === 1'b0, "R10 no start unarmed", int'(drv_en), 0);
        det_req = 0; run(1, 0); det_req = 1; cmp_in = 1;   // R4,R6 present
        run(3, 0); wait_cfg = 16'd40;      // R9 mid-sequence change
        run(15, 0);
        chk(m_done_cnt == 1, "R7 first result", m_done_cnt, 1);
        run(6, 0);                          // R10 held high: no restart
        det_req = 0; wait_cfg = 0; run(1, 0); det_req = 1;   // R9 zero wait
        run(2, 1); det_req = 0; pwr_state = 2'b00; run(2, 1); det_req = 1;  // R12
        run(10, 1);
        det_req = 0; pwr_state = 2'b10; wait_cfg = 16'd7; run(1, 0);
        det_req = 1; run(20, 1);            // R5 toggling comparator
        det_req = 0; pwr_state = 2'b11; run(1, 0); det_req = 1;   // R3
        run(6, 0);
        det_req = 0; pwr_state = 2'b00; run(1, 0); det_req = 1; run(3, 0);
        pwr_state = 2'b10; det_req = 0; run(1, 0); det_req = 1;
        run(3, 0); rst_n = 0; run(2, 0); rst_n = 1;   // R11 mid-sequence reset
        run(4, 0);
        det_req = 0; wait_cfg = 16'd3; cmp_in = 0; run(1, 0); det_req = 1;
        run(15, 0);
        chk(dut_done_cnt == m_done_cnt, "R7 result count", dut_done_cnt, m_done_cnt);
        summary();
    end
endmodule